// File: doc/BRIEF.md
# Circular Return Address Stack

This block keeps the return addresses of a small processor core. When the core's sequencer takes a subroutine call or vectors to an interrupt handler, it strobes a push with the 13-bit program counter value to save. When it executes any of the return forms, it strobes a pop. The block always shows the current top entry on a registered output, so the sequencer can load it into the program counter.

The storage is a fixed ring of eight entries. The pointer into the ring lives only inside the block and no path reads or writes it. Nothing checks the bounds in either direction. A ninth push lands on the slot the first push used. A pop on an empty stack hands back whatever entry the pointer reaches after stepping back. No overflow or underflow indication exists. The sequencer decides when to push or pop. If both strobes arrive in one cycle, the push wins and the simultaneous request is reported in simulation.

Top module: `ras_stack`

## Requirements
- R1: While `rst` is high on a rising clock edge, the internal pointer returns to slot 0 and `tos_o` becomes 0. `tos_o` stays 0 until the first push or pop after reset.
- R2: A push on a clock edge makes `tos_o` equal to the pushed `push_data_i`, visible right after that same edge.
- R3: A pop makes `tos_o` show the entry that was on top before the most recent still-stacked push, in last-in first-out order.
- R4: The ring holds 8 entries of 13 bits. After pushes v0..v8 from reset, v8 has overwritten v0. Eight pops that follow show v7, v6, ..., v1 and then v8 again.
- R5: The pointer steps back modulo 8 with no lower bound. After 8 pushes and 8 pops from reset, a further pop shows the entry written by the 7th push.
- R6: When push and pop are both high on one edge, the block behaves exactly as for a push alone.
- R7: On an edge where neither strobe is high, `tos_o` and the stack contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Save `push_data_i` as the new top entry |
| pop_i | input | 1 | Discard the top entry |
| push_data_i | input | 13 | Return address to save |
| tos_o | output | 13 | Current top-of-stack value, registered |

## Verification
A directed sequence of nine pushes followed by eight pops tells correct wrap-around overwrite apart from clamping at the top or a stack that refuses the extra push. Further pops past the empty point show whether the pointer really wraps downward or sticks at zero. Simultaneous push and pop strobes separate push priority from pop priority and from a combined replace. A long seeded random mix of push, pop, both and idle, started from a full stack, is compared with a bench model of the ring. This catches pointer and read-bypass errors that appear only in uncommon back-to-back orderings.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Operation selected for one clock edge; push outranks pop.
  typedef enum logic [1:0] {
    RAS_IDLE = 2'd0,
    RAS_PUSH = 2'd1,
    RAS_POP  = 2'd2
  } ras_op_e;

  function automatic ras_op_e ras_decode(input logic push, input logic pop);
    if (push)     return RAS_PUSH;
    else if (pop) return RAS_POP;
    else          return RAS_IDLE;
  endfunction

endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr
);

  // sp_q indexes the next free slot; the top entry sits at sp_q - 1.
  logic [AW-1:0] sp_q;
  logic [AW-1:0] sp_nxt;
  ras_op_e       op;

  always_comb begin
    op = ras_decode(push, pop);
    unique case (op)
      RAS_PUSH: sp_nxt = sp_q + AW'(1);
      RAS_POP:  sp_nxt = sp_q - AW'(1);
      default:  sp_nxt = sp_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sp_q <= '0;
    else     sp_q <= sp_nxt;
  end

  assign wr_en   = (op == RAS_PUSH);
  assign wr_addr = sp_q;
  assign rd_en   = (op != RAS_IDLE);
  assign rd_addr = sp_nxt - AW'(1);

endmodule

// File: rtl/ras_mem.sv
module ras_mem #(
  parameter int WIDTH = 13,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  // Storage has no reset so it maps onto plain RAM cells.
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read with write-first bypass; the output register alone is reset.
  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '0;
    else if (rd_en) begin
      if (wr_en && (wr_addr == rd_addr)) rd_q <= wr_data;
      else                               rd_q <= mem[rd_addr];
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
  parameter int WIDTH = 13,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic [WIDTH-1:0] tos_o
);

  localparam int AW = $clog2(DEPTH);

  logic          wr_en;
  logic          rd_en;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .push    (push_i),
    .pop     (pop_i),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr)
  );

  ras_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (push_data_i),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (tos_o)
  );

endmodule

// File: rtl/ras_stack_chk.sv
module ras_stack_chk #(
  parameter int WIDTH = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             push_i,
  input logic             pop_i,
  input logic [WIDTH-1:0] push_data_i,
  input logic [WIDTH-1:0] tos_o
);

  logic [1:0] live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= '0;
    else if (live_q != 2'd3) live_q <= live_q + 2'd1;
  end

  // R6: simultaneous strobes are legal but reported
  always_ff @(posedge clk) begin
    if (!rst && push_i && pop_i)
      $display("NOTE: push and pop together at %0t, push taken", $time);
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> tos_o == '0);

  // R2
  push_top_chk: assert property (@(posedge clk) disable iff (rst)
    push_i |=> tos_o == $past(push_data_i));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!push_i && !pop_i && live_q != 2'd0) |=> $stable(tos_o));

  // R3
  pop_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q == 2'd3 && pop_i && !push_i && $past(push_i)) |=> tos_o == $past(tos_o, 2));

endmodule

bind ras_stack ras_stack_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .push_data_i (push_data_i),
  .tos_o       (tos_o)
);

// File: tb/test_ras_stack.sv
`timescale 1ns/1ps
module test_ras_stack;

  localparam int W = 13;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         push_i = 1'b0;
  logic         pop_i = 1'b0;
  logic [W-1:0] push_data_i = '0;
  logic [W-1:0] tos_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] mdl [D];
  int           msp = 0;
  logic [W-1:0] exp_tos = '0;

  always #2 clk = ~clk;

  ras_stack #(.WIDTH(W), .DEPTH(D)) i_ras_stack (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i),
    .push_data_i(push_data_i), .tos_o(tos_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench model of the ring: push writes the free slot, pop steps back.
  function automatic logic [W-1:0] model_step(input bit p, input bit q, input logic [W-1:0] d);
    if (p) begin
      mdl[msp] = d;
      msp = (msp + 1) % D;
      return d;
    end else if (q) begin
      msp = (msp + D - 1) % D;
      return mdl[(msp + D - 1) % D];
    end
    return exp_tos;
  endfunction

  task automatic op(input bit p, input bit q, input logic [W-1:0] d, input string req);
    push_i = p; pop_i = q; push_data_i = d;
    @(posedge clk); #1;
    exp_tos = model_step(p, q, d);
    push_i = 1'b0; pop_i = 1'b0;
    check(req, tos_o, exp_tos);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    msp = 0; exp_tos = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    check("R1 reset", tos_o, '0);
    repeat (3) op(1'b0, 1'b0, '0, "R1 R7 idle after reset");

    // R2/R4: nine pushes, last overwrites the first slot
    for (int i = 0; i < 9; i++) op(1'b1, 1'b0, W'(13'h100 + i), "R2 push");
    // R3/R4: pops unwind v7..v1 then wrap to v8
    for (int i = 0; i < 7; i++) op(1'b0, 1'b1, '0, "R3 pop order");
    op(1'b0, 1'b1, '0, "R4 wrap returns ninth push");
    check("R4 wrapped value", tos_o, 13'h108);

    // R5: fresh ring, 8 pushes, 8 pops, one more pop wraps below zero
    do_reset();
    for (int i = 0; i < 8; i++) op(1'b1, 1'b0, W'(13'h0A0 + i), "R2 fill");
    for (int i = 0; i < 8; i++) op(1'b0, 1'b1, '0, "R3 drain");
    op(1'b0, 1'b1, '0, "R5 underflow pop");
    check("R5 underflow shows 7th push", tos_o, 13'h0A6);

    // R6: simultaneous strobes act as push
    op(1'b1, 1'b1, 13'h1ABC, "R6 push wins");
    op(1'b0, 1'b1, '0, "R6 pop after combined");
    op(1'b0, 1'b0, '0, "R7 idle hold");

    // Random mix on a fully written ring
    do_reset();
    for (int i = 0; i < 8; i++) op(1'b1, 1'b0, W'($urandom), "R2 prefill");
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 3));
      logic [W-1:0] d = W'($urandom);
      case (r)
        0: op(1'b1, 1'b0, d, "R2 random push");
        1: op(1'b0, 1'b1, d, "R3 random pop");
        2: op(1'b1, 1'b1, d, "R6 random both");
        default: op(1'b0, 1'b0, d, "R7 random idle");
      endcase
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule